// File: doc/BRIEF.md
# RMII Receive Dibit Deserializer

This block sits on the MAC side of a 100 Mbps reduced media-independent interface. On every edge of the 50 MHz reference clock it takes in the carrier/data-valid strobe, the two receive data bits and the receive-error bit. It skips the zero dibits that a PHY may present while it is still decoding. It then locks to the preamble and the start-of-frame delimiter, which fixes byte alignment. After that it packs the payload dibits into bytes on a simple valid-qualified byte stream.

Each output beat carries one byte with start and end markers. The end beat also carries two flags. The error flag is set when the receive-error bit was high at any point while the strobe was high. The alignment flag is set when the frame stopped partway through a byte. The block holds one complete byte in reserve so that it can mark the final complete byte as the end of the frame at the moment the strobe falls.

Top module: `rmii_rx_deser`

## Requirements
- R1: Any number of 00 dibits received after `crs_dv_i` rises and before the first 01 dibit are discarded and never appear in output data.
- R2: Payload starts with the dibit after a 11 dibit that was immediately preceded by at least MIN_PRE (default 4) consecutive 01 dibits. A 11 after fewer 01 dibits, or any 00 or 10 dibit once the 01 run has begun, drops the whole frame.
- R3: Payload dibits are packed least significant first. The first dibit of each byte lands in bits [1:0] and the fourth in bits [7:6].
- R4: Each complete payload byte appears exactly once as a one-cycle beat with `byte_valid_o` high. `byte_sof_o` marks the first beat of a frame and `byte_eof_o` marks the beat of the final complete byte. Both are set on a one-byte frame.
- R5: `byte_err_o` is set on the end beat exactly when `rx_er_i` was high in at least one cycle with `crs_dv_i` high during that frame. It does not carry over into the next frame.
- R6: While `crs_dv_i` is low, the values on `rxd_i` and `rx_er_i` have no effect. After two consecutive low samples of `crs_dv_i`, no beat is produced.
- R7: When `crs_dv_i` falls with one to three payload dibits past the last byte boundary, those dibits are dropped and `byte_align_o` is set on the end beat. Otherwise it stays clear.
- R8: A frame in which `crs_dv_i` falls before the delimiter, or before the first complete payload byte, produces no beat.
- R9: While reset is held, and on the first edge after release, `byte_valid_o` and all marker and flag outputs are low.
- R10: The end beat of a frame appears on the cycle after the edge at which `crs_dv_i` is first sampled low. A frame followed by a single low cycle can be followed at once by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| crs_dv_i | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd_i | input | 2 | Received dibit |
| rx_er_i | input | 1 | Receive error from the PHY |
| byte_valid_o | output | 1 | Output beat valid |
| byte_data_o | output | 8 | Assembled payload byte |
| byte_sof_o | output | 1 | First byte of frame |
| byte_eof_o | output | 1 | Final complete byte of frame |
| byte_err_o | output | 1 | Frame saw a receive error (end beat only) |
| byte_align_o | output | 1 | Frame ended on a partial byte (end beat only) |

## Verification
The hardest case to reach is the combination of strobe fall, pending byte and flags. The receive error must land on the very last dibit, the frame must end one, two or three dibits past a byte boundary, and the next frame must begin after a single idle cycle. The bench sweeps leading-zero count, preamble length, payload length, trailing partial dibits and error placement over every combination. It fills the idle gaps with nonzero dibits and a high error bit. It also sends frames whose delimiter is corrupted or arrives too early, so that nothing may come out of them.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_PRE,
    ST_BODY,
    ST_DROP
  } align_st_e;

  localparam logic [1:0] DIBIT_ZERO = 2'b00;
  localparam logic [1:0] DIBIT_PRE  = 2'b01;
  localparam logic [1:0] DIBIT_SFD  = 2'b11;

endpackage

// File: rtl/rmii_sfd_hunt.sv
module rmii_sfd_hunt
  import rmii_rx_pkg::*;
#(
  parameter int MIN_PRE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       crs_dv_i,
  input  logic [1:0] rxd_i,
  output logic       body_o,
  output logic       frame_end_o
);

  localparam int PCW = $clog2(MIN_PRE + 1);
  localparam logic [PCW-1:0] PRE_SAT = PCW'(MIN_PRE);

  align_st_e      st_q, st_n;
  logic [PCW-1:0] run_q, run_n;

  always_comb begin
    st_n  = st_q;
    run_n = run_q;
    if (!crs_dv_i) begin
      st_n  = ST_IDLE;
      run_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_HUNT: begin
          if (rxd_i == DIBIT_ZERO) begin
            st_n = ST_HUNT;
          end else if (rxd_i == DIBIT_PRE) begin
            st_n  = ST_PRE;
            run_n = PCW'(1);
          end else begin
            st_n = ST_DROP;
          end
        end
        ST_PRE: begin
          if (rxd_i == DIBIT_PRE) begin
            if (run_q != PRE_SAT) run_n = run_q + PCW'(1);
          end else if (rxd_i == DIBIT_SFD && run_q == PRE_SAT) begin
            st_n = ST_BODY;
          end else begin
            st_n = ST_DROP;
          end
        end
        ST_BODY: st_n = ST_BODY;
        default: st_n = ST_DROP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      run_q <= '0;
    end else begin
      st_q  <= st_n;
      run_q <= run_n;
    end
  end

  assign body_o      = (st_q == ST_BODY) && crs_dv_i;
  assign frame_end_o = (st_q == ST_BODY) && !crs_dv_i;

endmodule

// File: rtl/rmii_byte_pack.sv
module rmii_byte_pack #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [1:0]        rxd_i,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              partial_o
);

  localparam int DIBITS = DATA_W / 2;
  localparam int CW     = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DIBITS - 1);

  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CW-1:0]     cnt_q, cnt_n;

  always_comb begin
    sh_n  = {rxd_i, sh_q[DATA_W-1:2]};
    cnt_n = '0;
    if (take_i && cnt_q != LAST_IDX) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (take_i) sh_q <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign byte_done_o = take_i && (cnt_q == LAST_IDX);
  assign byte_o      = sh_n;
  assign partial_o   = (cnt_q != '0);

endmodule

// File: rtl/rmii_frame_out.sv
module rmii_frame_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crs_dv_i,
  input  logic              rx_er_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              frame_end_i,
  input  logic              partial_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              err_o,
  output logic              align_o
);

  logic              err_q, err_n;
  logic              pv_q, pv_n;
  logic [DATA_W-1:0] pd_q, pd_n;
  logic              pf_q, pf_n;
  logic              vld_n, sof_n, eof_n, oerr_n, align_n;
  logic [DATA_W-1:0] data_n;
  logic              pend_en;

  always_comb begin
    err_n   = crs_dv_i ? (err_q | rx_er_i) : 1'b0;
    pv_n    = pv_q;
    pd_n    = pd_q;
    pf_n    = pf_q;
    pend_en = 1'b0;
    vld_n   = 1'b0;
    data_n  = '0;
    sof_n   = 1'b0;
    eof_n   = 1'b0;
    oerr_n  = 1'b0;
    align_n = 1'b0;
    if (frame_end_i) begin
      if (pv_q) begin
        vld_n   = 1'b1;
        data_n  = pd_q;
        sof_n   = pf_q;
        eof_n   = 1'b1;
        oerr_n  = err_q;
        align_n = partial_i;
      end
      pv_n = 1'b0;
    end else if (byte_done_i) begin
      if (pv_q) begin
        vld_n  = 1'b1;
        data_n = pd_q;
        sof_n  = pf_q;
      end
      pend_en = 1'b1;
      pd_n    = byte_i;
      pf_n    = !pv_q;
      pv_n    = 1'b1;
    end else if (!crs_dv_i) begin
      pv_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      pv_q    <= 1'b0;
      pd_q    <= '0;
      pf_q    <= 1'b0;
      vld_o   <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      err_o   <= 1'b0;
      align_o <= 1'b0;
    end else begin
      err_q <= err_n;
      pv_q  <= pv_n;
      if (pend_en) begin
        pd_q <= pd_n;
        pf_q <= pf_n;
      end
      vld_o   <= vld_n;
      data_o  <= data_n;
      sof_o   <= sof_n;
      eof_o   <= eof_n;
      err_o   <= oerr_n;
      align_o <= align_n;
    end
  end

endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
  parameter int DATA_W  = 8,
  parameter int MIN_PRE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crs_dv_i,
  input  logic [1:0]        rxd_i,
  input  logic              rx_er_i,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic              byte_sof_o,
  output logic              byte_eof_o,
  output logic              byte_err_o,
  output logic              byte_align_o
);

  logic              body;
  logic              frame_end;
  logic              byte_done;
  logic [DATA_W-1:0] byte_w;
  logic              partial;

  rmii_sfd_hunt #(.MIN_PRE(MIN_PRE)) u_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .crs_dv_i    (crs_dv_i),
    .rxd_i       (rxd_i),
    .body_o      (body),
    .frame_end_o (frame_end)
  );

  rmii_byte_pack #(.DATA_W(DATA_W)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (body),
    .rxd_i       (rxd_i),
    .byte_done_o (byte_done),
    .byte_o      (byte_w),
    .partial_o   (partial)
  );

  rmii_frame_out #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .crs_dv_i    (crs_dv_i),
    .rx_er_i     (rx_er_i),
    .byte_done_i (byte_done),
    .byte_i      (byte_w),
    .frame_end_i (frame_end),
    .partial_i   (partial),
    .vld_o       (byte_valid_o),
    .data_o      (byte_data_o),
    .sof_o       (byte_sof_o),
    .eof_o       (byte_eof_o),
    .err_o       (byte_err_o),
    .align_o     (byte_align_o)
  );

endmodule

// File: rtl/rmii_rx_chk.sv
module rmii_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic crs_dv_i,
  input logic byte_valid_o,
  input logic byte_sof_o,
  input logic byte_eof_o,
  input logic byte_err_o,
  input logic byte_align_o
);

  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
    end else if (byte_valid_o) begin
      open_q <= !byte_eof_o;
    end
  end

  a_r6_quiet_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crs_dv_i && !$past(crs_dv_i)) |=> !byte_valid_o);

  a_r4_sof_opens_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_sof_o) |-> !open_q);

  a_r4_mid_beat_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_sof_o) |-> open_q);

  a_r5_flags_on_end_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_err_o || byte_align_o) |-> (byte_valid_o && byte_eof_o));

  a_r8_beat_follows_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(crs_dv_i, 2));

  a_r9_markers_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_sof_o || byte_eof_o) |-> byte_valid_o);

endmodule

bind rmii_rx_deser rmii_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .crs_dv_i     (crs_dv_i),
  .byte_valid_o (byte_valid_o),
  .byte_sof_o   (byte_sof_o),
  .byte_eof_o   (byte_eof_o),
  .byte_err_o   (byte_err_o),
  .byte_align_o (byte_align_o)
);

// File: tb/sim_rmii_rx_deser.sv
module sim_rmii_rx_deser;

  logic       clk;
  logic       rst_n;
  logic       crs;
  logic [1:0] rxd;
  logic       rxer;
  logic       vld, sof, eof, err, aln;
  logic [7:0] data;

  int checks;
  int errors;
  bit done;

  logic [7:0] g_data [256];
  logic       g_sof  [256];
  logic       g_eof  [256];
  logic       g_err  [256];
  logic       g_aln  [256];
  int         got_n;
  int         base;

  rmii_rx_deser u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .crs_dv_i     (crs),
    .rxd_i        (rxd),
    .rx_er_i      (rxer),
    .byte_valid_o (vld),
    .byte_data_o  (data),
    .byte_sof_o   (sof),
    .byte_eof_o   (eof),
    .byte_err_o   (err),
    .byte_align_o (aln)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && vld) begin
      g_data[got_n & 255] = data;
      g_sof[got_n & 255]  = sof;
      g_eof[got_n & 255]  = eof;
      g_err[got_n & 255]  = err;
      g_aln[got_n & 255]  = aln;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int f, input int i);
    return 8'((f * 29 + i * 53 + 7) & 255);
  endfunction

  task automatic put(input logic c, input logic [1:0] d, input logic e);
    crs  = c;
    rxd  = d;
    rxer = e;
    @(negedge clk);
  endtask

  // errmode: 0 none, 1 on first dibit after rise, 2 on last dibit
  task automatic frame(input int f, input int lead, input int pre, input bit sfd_ok,
                       input int nby, input int npart, input int errmode);
    int total;
    int k;
    bit expect_out;
    int n;
    total = lead + pre + 1 + nby * 4 + npart;
    k = 0;
    for (int i = 0; i < lead; i++) begin
      put(1'b1, 2'b00, (errmode == 1 && k == 0) || (errmode == 2 && k == total - 1)); k++;
    end
    for (int i = 0; i < pre; i++) begin
      put(1'b1, 2'b01, (errmode == 1 && k == 0) || (errmode == 2 && k == total - 1)); k++;
    end
    put(1'b1, sfd_ok ? 2'b11 : 2'b10,
        (errmode == 1 && k == 0) || (errmode == 2 && k == total - 1)); k++;
    for (int b = 0; b < nby; b++) begin
      logic [7:0] v;
      v = pay(f, b);
      for (int j = 0; j < 4; j++) begin
        put(1'b1, v[2*j +: 2], (errmode == 1 && k == 0) || (errmode == 2 && k == total - 1));
        k++;
      end
    end
    for (int j = 0; j < npart; j++) begin
      put(1'b1, 2'(j + 1), (errmode == 1 && k == 0) || (errmode == 2 && k == total - 1)); k++;
    end
    // idle gap with noise on data and error lines (R6)
    put(1'b0, 2'b11, 1'b1);
    put(1'b0, 2'b10, 1'b1);
    put(1'b0, 2'b00, 1'b0);
    expect_out = sfd_ok && (pre >= 4) && (nby >= 1);
    n = got_n - base;
    chk(n == (expect_out ? nby : 0), expect_out ? "R4" : (sfd_ok ? "R8" : "R2"),
        "beat count", n, expect_out ? nby : 0);
    if (expect_out && n == nby) begin
      for (int b = 0; b < nby; b++) begin
        int x;
        x = (base + b) & 255;
        chk(g_data[x] == pay(f, b), lead > 0 ? "R1" : "R3", "data", g_data[x], pay(f, b));
        chk(g_sof[x] == (b == 0), "R4", "sof", g_sof[x], b == 0);
        chk(g_eof[x] == (b == nby - 1), "R4", "eof", g_eof[x], b == nby - 1);
        chk(g_err[x] == ((b == nby - 1) && errmode != 0), "R5", "err flag", g_err[x],
            (b == nby - 1) && errmode != 0);
        chk(g_aln[x] == ((b == nby - 1) && npart != 0), "R7", "align flag", g_aln[x],
            (b == nby - 1) && npart != 0);
      end
    end
    base = got_n;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    got_n  = 0;
    base   = 0;
    rst_n  = 1'b0;
    crs    = 1'b0;
    rxd    = 2'b00;
    rxer   = 1'b0;
    repeat (3) @(negedge clk);
    chk(!vld && !sof && !eof && !err && !aln, "R9", "outputs in reset",
        {vld, sof, eof, err, aln}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!vld && !sof && !eof, "R9", "outputs after release", {vld, sof, eof}, 0);
    // noise while idle only (R6)
    put(1'b0, 2'b01, 1'b1);
    put(1'b0, 2'b11, 1'b0);
    put(1'b0, 2'b10, 1'b1);
    chk(got_n == 0, "R6", "idle noise beats", got_n, 0);

    begin
      int f;
      f = 0;
      for (int lead = 0; lead < 3; lead++)
        for (int pi = 0; pi < 4; pi++)
          for (int nby = 0; nby < 5; nby++)
            for (int np = 0; np < 4; np++)
              for (int em = 0; em < 3; em++) begin
                int pre;
                pre = (pi == 0) ? 2 : (pi == 1) ? 3 : (pi == 2) ? 4 : 7;
                frame(f, lead, pre, 1'b1, nby, np, em);
                f++;
              end
      // corrupted delimiter (R2)
      for (int nby = 1; nby < 4; nby++) begin
        frame(f, 1, 6, 1'b0, nby, 0, 0);
        f++;
      end
      // clean frame after an errored one: flag must not leak (R5)
      frame(f, 0, 5, 1'b1, 3, 0, 2); f++;
      frame(f, 0, 5, 1'b1, 3, 0, 0); f++;
    end

    // back-to-back frames with one idle cycle (R10)
    begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'hA6;
      b = 8'h3C;
      for (int r = 0; r < 2; r++) begin
        logic [7:0] v;
        v = r == 0 ? a : b;
        for (int i = 0; i < 4; i++) put(1'b1, 2'b01, 1'b0);
        put(1'b1, 2'b11, 1'b0);
        for (int j = 0; j < 4; j++) put(1'b1, v[2*j +: 2], 1'b0);
        crs = 1'b0; rxd = 2'b00; rxer = 1'b0;
        @(posedge clk);
        #1;
        chk(vld && eof && sof && data == v, "R10", "end beat right after fall",
            {vld, eof, sof, data}, {3'b111, v});
        @(negedge clk);
      end
      repeat (2) @(negedge clk);
      base = got_n;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule